// File: doc/BRIEF.md
# DDR DRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a DDR synchronous DRAM. It takes the memory from power-on to an idle state that is ready to use. First it holds clock enable low, with the command bus deselected, for a timed wait. It then raises clock enable and issues a fixed series of commands: a NOP, a precharge of all banks, and a write of the extended mode register (DLL enable and output drive strength). Next come a write of the mode register that also resets the DLL, a second precharge of all banks, two auto refreshes, and a final mode register write without the DLL reset. After each command the block drives NOP cycles for a gap set by a parameter.

When the series is done, the block raises `init_done` and keeps driving NOP with clock enable high, so that the main controller can take over the command bus. From then on a refresh interval timer raises `refresh_req` once per interval. The interval is derived from 4096 refreshes every 32 ms and from a clock-cycles-per-microsecond parameter. The request stays high until the controller acknowledges it.

The mode values (CAS latency, burst type, burst length code, DLL disable, reduced drive strength) come in on static input pins. The block places them in the address bits that the memory decodes.

Top module: `dram_bringup_seq`

## Requirements
- R1: From reset release, `mem_cke` stays low and `mem_cs_n` stays high (deselect) for exactly PWR = CYC_PER_US*PWRUP_US cycles. `mem_cke` is first seen high PWR+1 rising edges after reset release. During reset `mem_cke`=0, `mem_cs_n`=1, `init_done`=0 and `refresh_req`=0.
- R2: Once `mem_cke` is high, it stays high until the next reset.
- R3: Command encodings on {cs_n,ras_n,cas_n,we_n} are: NOP=0111, precharge=0010, auto refresh=0001, mode register write=0000.
- R4: After clock enable rises, the non-NOP commands come in this order: precharge, extended mode write, mode write with DLL reset, precharge, auto refresh, auto refresh, mode write.
- R5: Both precharges drive `mem_addr` bit 10 high and all other address bits and `mem_ba` zero, which selects all banks.
- R6: The extended mode write drives `mem_ba`=1, with address bit 0 = `mode_dll_off`, address bit 1 = `mode_drive_reduced`, and all other address bits zero.
- R7: Both mode writes drive `mem_ba`=0, with address bits [2:0] = `mode_burst_code`, bit 3 = `mode_interleave`, bits [6:4] = 3'b011 when `mode_cl3` is 1 and 3'b010 otherwise, and all other bits zero. The exception is bit 8, which is 1 on the first mode write (DLL reset) and 0 on the second.
- R8: The number of cycles between one command and the next is: 1 from the clock-enable rise to the first precharge, T_RP after each precharge, T_MRD after each mode or extended mode write, and T_RFC after each auto refresh.
- R9: Every cycle with clock enable high that carries none of the listed commands shows NOP on the command pins.
- R10: `init_done` stays low until exactly T_MRD cycles after the final mode write, and then stays high until reset.
- R11: `refresh_req` is low before `init_done`. It first rises exactly INT = CYC_PER_US*32000/4096 cycles after `init_done` rises.
- R12: `refresh_req` stays high until `refresh_ack` is seen at a rising edge, and is then low in the next cycle. The timer keeps running, so the next request rises INT cycles after the previous one, whenever the acknowledge came.
- R13: After `init_done`, the block issues no further commands. The pins stay at NOP with clock enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_dll_off | input | 1 | Value for the extended mode DLL-disable bit |
| mode_drive_reduced | input | 1 | Value for the extended mode reduced-drive bit |
| mode_cl3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| mode_interleave | input | 1 | Burst type bit, 1 = interleaved |
| mode_burst_code | input | 3 | Burst length code placed in address bits [2:0] |
| refresh_ack | input | 1 | Controller acknowledge that clears `refresh_req` |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialisation complete |
| refresh_req | output | 1 | Periodic refresh request |

## Verification
The bench sets CYC_PER_US to 2, which shortens the power-up wait to 400 cycles and the refresh interval to 15 cycles. This allows two full bring-ups, each with a different set of mode values, and several refresh intervals in one short run. It also picks T_RP=3, T_MRD=2 and T_RFC=8, which are distinct from each other, so a gap taken from the wrong timing parameter shows up as a wrong cycle count between commands.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    ST_PWR_WAIT = 4'd0,
    ST_CKE_NOP  = 4'd1,
    ST_PRE_A    = 4'd2,
    ST_EXT_MODE = 4'd3,
    ST_MODE_DLL = 4'd4,
    ST_PRE_B    = 4'd5,
    ST_REF_A    = 4'd6,
    ST_REF_B    = 4'd7,
    ST_MODE_FIN = 4'd8,
    ST_IDLE     = 4'd9
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_DESEL = 4'b1111;
  localparam cmd_t CMD_NOP   = 4'b0111;
  localparam cmd_t CMD_PRE   = 4'b0010;
  localparam cmd_t CMD_AREF  = 4'b0001;
  localparam cmd_t CMD_MRS   = 4'b0000;

  // Address bit positions decoded by the memory
  localparam int PRE_ALL_BIT   = 10;
  localparam int DLL_RESET_BIT = 8;

endpackage

// File: rtl/dram_step_ctrl.sv
module dram_step_ctrl
  import dram_seq_pkg::*;
#(
  parameter int PWR_CYC = 20000,
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 12
) (
  input  logic  clk,
  input  logic  rst_n,
  output step_e step,
  output logic  first
);
  localparam int MAX_A   = (PWR_CYC > T_RFC) ? PWR_CYC : T_RFC;
  localparam int MAX_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  step_e            step_q, step_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_m1;
  logic             last;

  // Length of each step, command cycle included
  always_comb begin
    unique case (step_q)
      ST_PWR_WAIT:                         len_m1 = CNT_W'(PWR_CYC - 1);
      ST_PRE_A, ST_PRE_B:                  len_m1 = CNT_W'(T_RP - 1);
      ST_EXT_MODE, ST_MODE_DLL,
      ST_MODE_FIN:                         len_m1 = CNT_W'(T_MRD - 1);
      ST_REF_A, ST_REF_B:                  len_m1 = CNT_W'(T_RFC - 1);
      default:                             len_m1 = '0;
    endcase
  end

  assign last = (cnt_q == len_m1);

  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q + 1'b1;
    if (step_q == ST_IDLE) begin
      cnt_d = '0;
    end else if (last) begin
      cnt_d  = '0;
      step_d = step_e'(step_q + 4'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_PWR_WAIT;
      cnt_q  <= '0;
    end else begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
    end
  end

  assign step  = step_q;
  assign first = (cnt_q == '0);

  assert_gap_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_LEN));

  assert_order_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != ST_IDLE) |=> (step_q == $past(step_q)) ||
                            (step_q == step_e'($past(step_q) + 4'd1)));

  assert_idle_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_IDLE) |=> (step_q == ST_IDLE));

endmodule

// File: rtl/dram_cmd_encode.sv
module dram_cmd_encode
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  step_e              step,
  input  logic               first,
  input  logic               dll_off,
  input  logic               drive_reduced,
  input  logic               cl3,
  input  logic               interleave,
  input  logic [2:0]         burst_code,
  output logic               cke,
  output cmd_t               cmd,
  output logic [BA_W-1:0]    ba,
  output logic [ADDR_W-1:0]  addr,
  output logic               ready
);
  logic [ADDR_W-1:0] mode_word;
  logic [ADDR_W-1:0] ext_word;
  logic [ADDR_W-1:0] pre_word;

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = burst_code;
    mode_word[3]   = interleave;
    mode_word[6:4] = cl3 ? 3'b011 : 3'b010;
    ext_word       = '0;
    ext_word[0]    = dll_off;
    ext_word[1]    = drive_reduced;
    pre_word       = '0;
    pre_word[PRE_ALL_BIT] = 1'b1;
  end

  always_comb begin
    cke   = 1'b1;
    cmd   = CMD_NOP;
    ba    = '0;
    addr  = '0;
    ready = 1'b0;
    unique case (step)
      ST_PWR_WAIT: begin
        cke = 1'b0;
        cmd = CMD_DESEL;
      end
      ST_PRE_A, ST_PRE_B: if (first) begin
        cmd  = CMD_PRE;
        addr = pre_word;
      end
      ST_EXT_MODE: if (first) begin
        cmd  = CMD_MRS;
        ba   = BA_W'(1);
        addr = ext_word;
      end
      ST_MODE_DLL: if (first) begin
        cmd  = CMD_MRS;
        addr = mode_word;
        addr[DLL_RESET_BIT] = 1'b1;
      end
      ST_MODE_FIN: if (first) begin
        cmd  = CMD_MRS;
        addr = mode_word;
      end
      ST_REF_A, ST_REF_B: if (first) begin
        cmd = CMD_AREF;
      end
      ST_IDLE: ready = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ack,
  output logic req
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;
  logic          wrap;

  assign wrap = enable && (cnt_q == CW'(INTERVAL - 1));

  always_comb begin
    cnt_d = cnt_q;
    req_d = req_q;
    if (!enable)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
    if (wrap)      req_d = 1'b1;
    else if (ack)  req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

  assert_req_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> req_q);

  assert_no_req_early_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !req_q);

  assert_count_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(INTERVAL));

endmodule

// File: rtl/dram_bringup_seq.sv
module dram_bringup_seq
  import dram_seq_pkg::*;
#(
  parameter int CYC_PER_US    = 100,
  parameter int PWRUP_US      = 200,
  parameter int T_RP_CYC      = 3,
  parameter int T_MRD_CYC     = 2,
  parameter int T_RFC_CYC     = 12,
  parameter int REF_WINDOW_US = 32000,
  parameter int REF_COUNT     = 4096,
  parameter int ADDR_W        = 13,
  parameter int BA_W          = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dll_off,
  input  logic              mode_drive_reduced,
  input  logic              mode_cl3,
  input  logic              mode_interleave,
  input  logic [2:0]        mode_burst_code,
  input  logic              refresh_ack,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done,
  output logic              refresh_req
);
  localparam int PWR_CYC = CYC_PER_US * PWRUP_US;
  localparam int REF_INT = (CYC_PER_US * REF_WINDOW_US) / REF_COUNT;

  step_e             step;
  logic              first;
  logic              cke_d, ready_d;
  cmd_t              cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  logic              cke_q, ready_q;
  cmd_t              cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;

  dram_step_ctrl #(
    .PWR_CYC (PWR_CYC),
    .T_RP    (T_RP_CYC),
    .T_MRD   (T_MRD_CYC),
    .T_RFC   (T_RFC_CYC)
  ) u_steps (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .first (first)
  );

  dram_cmd_encode #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_encode (
    .step          (step),
    .first         (first),
    .dll_off       (mode_dll_off),
    .drive_reduced (mode_drive_reduced),
    .cl3           (mode_cl3),
    .interleave    (mode_interleave),
    .burst_code    (mode_burst_code),
    .cke           (cke_d),
    .cmd           (cmd_d),
    .ba            (ba_d),
    .addr          (addr_d),
    .ready         (ready_d)
  );

  // Output pin register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q   <= 1'b0;
      cmd_q   <= CMD_DESEL;
      ba_q    <= '0;
      addr_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      cke_q   <= cke_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      ready_q <= ready_d;
    end
  end

  dram_refresh_timer #(
    .INTERVAL (REF_INT)
  ) u_refresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (ready_q),
    .ack    (refresh_ack),
    .req    (refresh_req)
  );

  assign mem_cke   = cke_q;
  assign mem_cs_n  = cmd_q.cs_n;
  assign mem_ras_n = cmd_q.ras_n;
  assign mem_cas_n = cmd_q.cas_n;
  assign mem_we_n  = cmd_q.we_n;
  assign mem_ba    = ba_q;
  assign mem_addr  = addr_q;
  assign init_done = ready_q;

  assert_cke_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cke_q |=> cke_q);

  assert_deselect_in_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> cmd_q.cs_n);

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> (ready_q && cke_q));

  assert_idle_nop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> (cmd_q == CMD_NOP));

  assert_req_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> ready_q);

endmodule

// File: tb/test_dram_bringup_seq.sv
module test_dram_bringup_seq;

  localparam int CPU   = 2;
  localparam int PUS   = 200;
  localparam int TRP   = 3;
  localparam int TMRD  = 2;
  localparam int TRFC  = 8;
  localparam int AW    = 13;
  localparam int BW    = 2;
  localparam int PWR   = CPU * PUS;
  localparam int INT   = (CPU * 32000) / 4096;

  typedef struct {
    logic [3:0]    cmd;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;
    int            gap;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_dll_off = 1'b0, m_drv = 1'b0, m_cl3 = 1'b0, m_il = 1'b0;
  logic [2:0] m_bl = 3'b010;
  logic ref_ack = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done, req;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int last_cmd_cyc = 0;
  int cke_rise_cyc = 0;
  int done_cyc = 0;
  int last_mode_cyc = 0;
  bit cke_seen = 0;
  bit done_seen = 0;
  int nop_errs = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  dram_bringup_seq #(
    .CYC_PER_US (CPU), .PWRUP_US (PUS), .T_RP_CYC (TRP),
    .T_MRD_CYC (TMRD), .T_RFC_CYC (TRFC), .ADDR_W (AW), .BA_W (BW)
  ) i_dram_bringup_seq (
    .clk (clk), .rst_n (rst_n),
    .mode_dll_off (m_dll_off), .mode_drive_reduced (m_drv),
    .mode_cl3 (m_cl3), .mode_interleave (m_il), .mode_burst_code (m_bl),
    .refresh_ack (ref_ack),
    .mem_cke (cke), .mem_cs_n (cs_n), .mem_ras_n (ras_n),
    .mem_cas_n (cas_n), .mem_we_n (we_n), .mem_ba (ba), .mem_addr (addr),
    .init_done (done), .refresh_req (req)
  );

  task automatic check(bit ok, string req_tag, string what, longint act, longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, expv);
    end
  endtask

  // Driver: expected command stream for one bring-up
  task automatic push_expected(bit dll_off, bit drv, bit cl3, bit il, logic [2:0] bl);
    logic [AW-1:0] mw;
    exp_t e;
    mw = '0;
    mw[2:0] = bl;
    mw[3]   = il;
    mw[6:4] = cl3 ? 3'b011 : 3'b010;
    e.ba = '0; e.addr = '0; e.addr[10] = 1'b1;
    e.cmd = 4'b0010; e.gap = 1;    e.tag = "R5"; sb.push_back(e);
    e.ba = 2'd1; e.addr = '0; e.addr[0] = dll_off; e.addr[1] = drv;
    e.cmd = 4'b0000; e.gap = TRP;  e.tag = "R6"; sb.push_back(e);
    e.ba = '0; e.addr = mw; e.addr[8] = 1'b1;
    e.cmd = 4'b0000; e.gap = TMRD; e.tag = "R7"; sb.push_back(e);
    e.ba = '0; e.addr = '0; e.addr[10] = 1'b1;
    e.cmd = 4'b0010; e.gap = TMRD; e.tag = "R5"; sb.push_back(e);
    e.ba = '0; e.addr = '0;
    e.cmd = 4'b0001; e.gap = TRP;  e.tag = "R3"; sb.push_back(e);
    e.cmd = 4'b0001; e.gap = TRFC; e.tag = "R3"; sb.push_back(e);
    e.ba = '0; e.addr = mw;
    e.cmd = 4'b0000; e.gap = TRFC; e.tag = "R7"; sb.push_back(e);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Monitor: pops expected commands as the pins show them
  always @(negedge clk) begin
    logic [3:0] c;
    exp_t e;
    c = {cs_n, ras_n, cas_n, we_n};
    if (!rst_n) begin
      cke_seen  = 0;
      done_seen = 0;
    end else begin
      if (!cke && !cs_n) nop_errs++;
      if (cke && !cke_seen) begin
        cke_seen = 1;
        cke_rise_cyc = cyc;
        last_cmd_cyc = cyc;
        check(cyc == PWR + 1, "R1", "cke rise cycle", cyc, PWR + 1);
      end
      if (cke && cke_seen && !cs_n && c != 4'b0111) begin
        if (sb.size() == 0) begin
          check(0, "R13", "unexpected command", c, 4'b0111);
        end else begin
          e = sb.pop_front();
          check(c == e.cmd, "R4", "command order", c, e.cmd);
          check(ba == e.ba && addr == e.addr, e.tag, "bank/address",
                {ba, addr}, {e.ba, e.addr});
          check(cyc - last_cmd_cyc == e.gap, "R8", "command gap",
                cyc - last_cmd_cyc, e.gap);
          if (c == 4'b0000) last_mode_cyc = cyc;
        end
        last_cmd_cyc = cyc;
      end else if (cke && c != 4'b0111) begin
        nop_errs++;
      end
      if (done && !done_seen) begin
        done_seen = 1;
        done_cyc = cyc;
        check(sb.size() == 0 && cyc - last_mode_cyc == TMRD, "R10",
              "done after final mode write", cyc - last_mode_cyc, TMRD);
      end
      if (!done && done_seen) nop_errs++;
      if (!cke && cke_seen) nop_errs++;
      if (req && !done) nop_errs++;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic run_once(bit dll_off, bit drv, bit cl3, bit il, logic [2:0] bl);
    rst_n = 1'b0;
    m_dll_off = dll_off; m_drv = drv; m_cl3 = cl3; m_il = il; m_bl = bl;
    sb.delete();
    repeat (3) tick();
    check(!cke && cs_n && !done && !req, "R1", "reset state",
          {cke, cs_n, done, req}, 4'b0100);
    push_expected(dll_off, drv, cl3, il, bl);
    rst_n = 1'b1;
    while (!done) tick();
    check(sb.size() == 0, "R4", "all commands seen", sb.size(), 0);
    while (cyc < done_cyc + INT - 1) tick();
    check(!req, "R11", "no request before interval", req, 0);
    tick();
    check(req, "R11", "request at interval", req, 1);
    repeat (3) tick();
    check(req, "R12", "request held without ack", req, 1);
    ref_ack = 1'b1;
    tick();
    ref_ack = 1'b0;
    check(!req, "R12", "ack clears request", req, 0);
    while (cyc < done_cyc + 2 * INT - 1) tick();
    check(!req, "R12", "no request mid interval", req, 0);
    tick();
    check(req, "R12", "second request on schedule", req, 1);
    ref_ack = 1'b1;
    tick();
    ref_ack = 1'b0;
    repeat (20) tick();
    check(cke && done && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R13",
          "idle pins", {cke, done, cs_n, ras_n, cas_n, we_n}, 6'b110111);
  endtask

  initial begin
    run_once(1'b0, 1'b0, 1'b0, 1'b0, 3'b010);
    run_once(1'b1, 1'b1, 1'b1, 1'b1, 3'b011);
    check(nop_errs == 0, "R9", "NOP between commands / R2 cke hold", nop_errs, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule